// File: doc/BRIEF.md
# Signed Energy Quantum Accumulator Bank

The block holds three signed two's-complement energy counters, one per phase. An upstream pulse source sends single energy quanta to each phase as an up strobe or a down strobe. Each counter moves by exactly one per quantum and wraps freely at both ends of its signed range. When a counter's second-highest bit changes through counting, it is half full in one direction or the other. That event sets a shared sticky status bit. If the mask bit is set, the same event also pulls an active-low interrupt output low.

Host logic reads a counter through a selectable read port that answers in the same cycle. A strobe marks each read as taken. With the read-reset enable set, the counter that was read is cleared at the next clock edge. Writing a one to the status bit clears it, and the interrupt then returns high.

The counter width `W` defaults to 32, and the half-full bit is `W-2` (bit 30 by default).

Top module: `energy_quanta_bank`

## Requirements
- R1: After reset, every counter reads 0, `status_o` is 0 and `irq_no` is 1.
- R2: An up strobe alone adds one to that phase's counter at the next edge. 2^(W-1)-1 wraps to -2^(W-1) (0x7FFFFFFF to 0x80000000 by default), and counting continues upward.
- R3: A down strobe alone subtracts one at the next edge. -2^(W-1) wraps to 2^(W-1)-1, and counting continues downward.
- R4: Up and down strobes on the same phase in the same cycle leave that counter unchanged.
- R5: `status_o` is set at the edge where a counting step changes bit W-2 of any counter. Examples are 0x3FFFFFFF to 0x40000000 and 0xC0000000 to 0xBFFFFFFF, and wraps that cross that bit also count. A clear-on-read alone never sets it.
- R6: `irq_no` is low exactly while `status_o` is 1 and `hf_mask_i` is 1. With the mask set, the interrupt falls in the same cycle the status bit rises.
- R7: A cycle with `st_clr_i` high clears `status_o` at the next edge, and `irq_no` then returns high.
- R8: A half-full event in the same cycle as `st_clr_i` leaves `status_o` set.
- R9: `rd_data_o` shows, in the same cycle, the counter chosen by `rd_sel_i`, where 0, 1 and 2 select phases 0, 1 and 2.
- R10: When `rd_en_i` and `rd_rst_en_i` are both high, the selected counter becomes 0 at the next edge. With `rd_rst_en_i` low, a read leaves the counter unchanged.
- R11: A quantum arriving on the phase being cleared by a read loads that counter with +1 or -1 (all ones) instead of 0.
- R12: A select value of 3 or more reads as 0, and a read-reset at such a select changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | N_PH | Per-phase up quantum strobe |
| dn_i | input | N_PH | Per-phase down quantum strobe |
| rd_en_i | input | 1 | Read strobe for the selected counter |
| rd_sel_i | input | SELW | Counter select |
| rd_rst_en_i | input | 1 | Clear-on-read enable |
| rd_data_o | output | W | Selected counter value |
| st_clr_i | input | 1 | Write-one-to-clear for the half-full status |
| hf_mask_i | input | 1 | Half-full interrupt enable |
| status_o | output | 1 | Sticky half-full status |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions assume that the strobes, the read controls and the clear are synchronous, single-cycle-valid levels. They also assume that a quantum is a one-step change and never a multi-step jump. The stimulus drives every input on the falling edge, so each sampled value stays stable across the rising edge. A narrow width (W=8) lets the counters wrap through both signed limits many times within the run. The phases see repeating but different mixes of up, down and cancelling strobes, together with interleaved reads, read-resets and clears.

// File: rtl/eacc_pkg.sv
package eacc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  function automatic step_e step_decode(input logic up, input logic dn);
    if (up && !dn) return STEP_UP;
    if (dn && !up) return STEP_DN;
    return STEP_NONE;
  endfunction
endpackage

// File: rtl/eacc_phase_reg.sv
module eacc_phase_reg
  import eacc_pkg::*;
#(
  parameter int W      = 32,
  parameter int HF_BIT = W - 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic         hf_evt_o
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MONE = {W{1'b1}};

  step_e        step;
  logic [W-1:0] q_q, stepped, nxt;

  always_comb begin
    step = step_decode(up_i, dn_i);
    unique case (step)
      STEP_UP: stepped = q_q + ONE;
      STEP_DN: stepped = q_q - ONE;
      default: stepped = q_q;
    endcase
    // clear-on-read keeps a coincident quantum
    if (clr_i) begin
      unique case (step)
        STEP_UP: nxt = ONE;
        STEP_DN: nxt = MONE;
        default: nxt = '0;
      endcase
    end else begin
      nxt = stepped;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt;
  end

  assign q_o      = q_q;
  assign hf_evt_o = !clr_i && (stepped[HF_BIT] ^ q_q[HF_BIT]);

  // R2
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !dn_i && !clr_i) |=> (q_o == $past(q_o) + ONE));
  // R3
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i && !clr_i) |=> (q_o == $past(q_o) - ONE));
  // R4
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && dn_i && !clr_i) |=> (q_o == $past(q_o)));
  // R10
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !up_i && !dn_i) |=> (q_o == '0));
  // R11
  rd_clr_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && up_i && !dn_i) |=> (q_o == ONE));
  // R5
  hf_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_evt_o |=> (q_o[HF_BIT] != $past(q_o[HF_BIT])));
endmodule

// File: rtl/eacc_hf_irq.sv
module eacc_hf_irq #(
  parameter int N_PH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PH-1:0] hf_evt_i,
  input  logic            st_clr_i,
  input  logic            hf_mask_i,
  output logic            status_o,
  output logic            irq_no
);
  logic any_evt, status_q;

  assign any_evt = |hf_evt_i;

  // new event wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       status_q <= 1'b0;
    else if (any_evt)  status_q <= 1'b1;
    else if (st_clr_i) status_q <= 1'b0;
  end

  assign status_o = status_q;
  assign irq_no   = ~(status_q & hf_mask_i);

  // R5
  // R8
  hf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt |=> status_o);
  // R7
  hf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_clr_i && !any_evt) |=> (!status_o && irq_no));
  // R6
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o) && hf_mask_i) |-> !irq_no);
  // R6
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o |-> irq_no);
endmodule

// File: rtl/eacc_rd_port.sv
module eacc_rd_port #(
  parameter int N_PH = 3,
  parameter int W    = 32,
  parameter int SELW = 2
) (
  input  logic [N_PH-1:0][W-1:0] regs_i,
  input  logic [SELW-1:0]        sel_i,
  input  logic                   rd_en_i,
  input  logic                   rd_rst_en_i,
  output logic [W-1:0]           data_o,
  output logic [N_PH-1:0]        clr_o
);
  logic sel_ok;

  assign sel_ok = {1'b0, sel_i} < (SELW+1)'(N_PH);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_PH; i++)
      if (sel_i == SELW'(i)) data_o = regs_i[i];
  end

  for (genvar g = 0; g < N_PH; g++) begin : g_clr
    assign clr_o[g] = rd_en_i && rd_rst_en_i && (sel_i == SELW'(g));
  end

  // R10
  // R12
  clr_onehot_chk: assert property (@(posedge rd_en_i) 1'b1 |-> $onehot0(clr_o));
  always_comb begin
    // R12
    bad_sel_chk: assert (sel_ok || (data_o == '0 && clr_o == '0));
  end
endmodule

// File: rtl/energy_quanta_bank.sv
module energy_quanta_bank #(
  parameter int N_PH   = 3,
  parameter int W      = 32,
  parameter int HF_BIT = W - 2,
  parameter int SELW   = (N_PH > 1) ? $clog2(N_PH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PH-1:0] up_i,
  input  logic [N_PH-1:0] dn_i,
  input  logic            rd_en_i,
  input  logic [SELW-1:0] rd_sel_i,
  input  logic            rd_rst_en_i,
  output logic [W-1:0]    rd_data_o,
  input  logic            st_clr_i,
  input  logic            hf_mask_i,
  output logic            status_o,
  output logic            irq_no
);
  logic [N_PH-1:0][W-1:0] regs;
  logic [N_PH-1:0]        clr, hf_evt;

  for (genvar g = 0; g < N_PH; g++) begin : g_ph
    eacc_phase_reg #(.W(W), .HF_BIT(HF_BIT)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .up_i    (up_i[g]),
      .dn_i    (dn_i[g]),
      .clr_i   (clr[g]),
      .q_o     (regs[g]),
      .hf_evt_o(hf_evt[g])
    );
  end

  eacc_rd_port #(.N_PH(N_PH), .W(W), .SELW(SELW)) u_rd (
    .regs_i     (regs),
    .sel_i      (rd_sel_i),
    .rd_en_i    (rd_en_i),
    .rd_rst_en_i(rd_rst_en_i),
    .data_o     (rd_data_o),
    .clr_o      (clr)
  );

  eacc_hf_irq #(.N_PH(N_PH)) u_hf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hf_evt_i (hf_evt),
    .st_clr_i (st_clr_i),
    .hf_mask_i(hf_mask_i),
    .status_o (status_o),
    .irq_no   (irq_no)
  );

  // R1
  rst_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!status_o && irq_no));
endmodule

// File: tb/sim_energy_quanta_bank.sv
module sim_energy_quanta_bank;
  localparam int N  = 3;
  localparam int W  = 8;
  localparam int HB = W - 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] up = '0, dn = '0;
  logic         rd_en = 1'b0, rd_rst = 1'b0, st_clr = 1'b0, mask = 1'b0;
  logic [1:0]   sel = '0;
  logic [W-1:0] rd_data;
  logic         status, irq_n;

  int errors = 0, checks = 0, cycles = 0;
  logic [W-1:0] m [N];
  logic         m_st = 1'b0;

  always #10 clk = ~clk;

  energy_quanta_bank #(.N_PH(N), .W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn),
    .rd_en_i(rd_en), .rd_sel_i(sel), .rd_rst_en_i(rd_rst),
    .rd_data_o(rd_data), .st_clr_i(st_clr), .hf_mask_i(mask),
    .status_o(status), .irq_no(irq_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] u, input logic [N-1:0] d, input logic clr,
                     input logic rde, input logic rrst, input logic [1:0] s,
                     input logic msk, input string tag);
    logic         evt;
    logic [W-1:0] nv;
    @(negedge clk);
    up = u; dn = d; st_clr = clr; rd_en = rde; rd_rst = rrst; sel = s; mask = msk;
    #1;
    chk({tag, " R9"}, "rd_data", int'(rd_data), (s < 2'(N)) ? int'(m[s]) : 0);
    chk({tag, " R6"}, "irq_n", int'(irq_n), int'(!(m_st && msk)));
    evt = 1'b0;
    for (int p = 0; p < N; p++) begin
      int st;
      logic c;
      st = (u[p] && !d[p]) ? 1 : ((d[p] && !u[p]) ? -1 : 0);
      c  = rde && rrst && (s == 2'(p));
      if (c) nv = W'(st);
      else begin
        nv = m[p] + W'(st);
        if (nv[HB] != m[p][HB]) evt = 1'b1;
      end
      m[p] = nv;
    end
    m_st = evt || (m_st && !clr);
    @(posedge clk);
    #1;
    chk({tag, " R5"}, "status", int'(status), int'(m_st));
    chk({tag, " R6"}, "irq_n post", int'(irq_n), int'(!(m_st && msk)));
  endtask

  task automatic idle_read(input logic [1:0] s, input logic msk, input string tag);
    cyc('0, '0, 1'b0, 1'b0, 1'b0, s, msk, tag);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) m[p] = '0;
    #35;
    chk("R1", "status", int'(status), 0);
    chk("R1", "irq_n", int'(irq_n), 1);
    rst_n = 1'b1;
    for (int p = 0; p < N; p++) idle_read(2'(p), 1'b0, "R1");
    // R2 up to half-full, mask off
    for (int i = 0; i < 64; i++) cyc(3'b001, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R2");
    chk("R5", "status at 0x40", int'(status), 1);
    chk("R6", "irq masked off", int'(irq_n), 1);
    idle_read(2'd0, 1'b1, "R6");
    chk("R6", "irq low", int'(irq_n), 0);
    cyc('0, '0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, "R7");
    chk("R7", "irq high", int'(irq_n), 1);
    // R3 down from zero wraps to all ones
    cyc(3'b000, 3'b010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, "R3");
    idle_read(2'd1, 1'b1, "R3");
    // R4 cancel
    cyc(3'b110, 3'b110, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, "R4");
    idle_read(2'd2, 1'b1, "R4");
    idle_read(2'd1, 1'b1, "R4");
    // R8 event coincides with clear: 0x40 up to 0x7F then one more step with clear
    for (int i = 0; i < 63; i++) cyc(3'b001, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R2");
    cyc('0, '0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R7");
    cyc(3'b001, 3'b000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R8");
    chk("R8", "status kept", int'(status), 1);
    idle_read(2'd0, 1'b0, "R2");
    // R10 read without and with reset
    cyc('0, '0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R10");
    cyc('0, '0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R10");
    idle_read(2'd0, 1'b0, "R10");
    // R11 quantum during clear-on-read
    cyc(3'b010, 3'b000, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, "R11");
    idle_read(2'd1, 1'b0, "R11");
    cyc(3'b000, 3'b001, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R11");
    idle_read(2'd0, 1'b0, "R11");
    // R12 out-of-range select
    cyc('0, '0, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, "R12");
    for (int p = 0; p < N; p++) idle_read(2'(p), 1'b0, "R12");
    // mixed sweep: wraps both ways on every phase
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] u, d;
      u[0] = (i % 4 != 3);  d[0] = (i % 9 == 0);
      u[1] = (i % 11 == 0); d[1] = (i % 3 != 0);
      u[2] = (i % 2 == 0);  d[2] = (i % 3 == 0);
      cyc(u, d, (i % 13 == 0), (i % 37 == 5), ((i / 1000) % 2 == 1),
          2'(i % 4), ((i / 700) % 2 == 0), "R2 R3 R4 R10");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule